// File: doc/BRIEF.md
# Loop Predicate Generator with Condition Flags

This block produces the per-lane predicate that governs a vector-length-agnostic loop iteration, and along with it the four condition flags that the loop-control branch reads. A command strobe selects one of four operations: a lane-by-lane "index still below the bound" test on a 64-bit start index and end bound (signed or unsigned), an all-true pattern that lights a chosen number of leading lanes, or a query that returns how many elements of the selected size fit in the vector.

The vector length is a parameter, a multiple of 128 bits no larger than 2048 bits. Element size is an input. The predicate carries one bit per vector byte, and only the lowest byte of each element is meaningful. The flags come from the result read through a governing predicate input: N reports the first governed element, Z reports that no governed element is true, and C reports that the last governed element is false. V is always zero. Callers drive the governing input all-ones for the two predicate-building commands when full-vector semantics are wanted.

The results land in registers on the clock edge that samples the strobe, and a one-cycle completion pulse marks them.

Top module: `loop_pred_gen`

## Requirements
- R1: With `cmd`=0 (signed bound test), element k is true exactly when start+k < end as signed numbers, where start+k is formed without wraparound, so lanes that pass the largest positive index are false.
- R2: With `cmd`=1 (unsigned bound test), element k is true exactly when start+k < end as unsigned numbers, where start+k is formed without wraparound, so lanes at or above 2^64 are false.
- R3: `elemSize` codes 0, 1, 2, 3 select 8, 16, 32, 64-bit elements. Element k sits at predicate bit k*(elemSize bytes), and every other predicate bit is written zero.
- R4: With `cmd`=2 (all-true), the number of leading true elements L out of the lane count M is given by `pattern`: 0 gives M, 1 gives the largest multiple of 3 not above M, 2 gives the largest multiple of 4 not above M, 3 gives the largest power of two not above M, and 4, 5, 6, 7 give 1, 2, 4, 8 (or 0 if that exceeds M).
- R5: With `cmd`=3 (element count), `countOut` becomes VL_BITS/(8<<elemSize), and `predOut` and `flagsOut` keep their values.
- R6: `flagsOut[3]` (N) is the result bit of the lowest element whose governing bit is set, or 0 if none is set.
- R7: `flagsOut[2]` (Z) is 1 exactly when no element has both its governing bit and its result bit set.
- R8: `flagsOut[1]` (C) is the inverse of the result bit of the highest governed element, or 1 if none is set. With an empty governing predicate the flags are N=0, Z=1, C=1.
- R9: `flagsOut[0]` (V) is always 0.
- R10: Outputs change only on the rising edge that samples `cmdValid` high, and `done` is high for exactly the cycle after each strobe. Strobes in consecutive cycles are each carried out.
- R11: After reset `predOut`, `flagsOut`, `countOut` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmd | input | 2 | 0 signed bound test, 1 unsigned bound test, 2 all-true, 3 element count |
| elemSize | input | 2 | Element size code: 8, 16, 32, 64 bits |
| pattern | input | 3 | Lane-count pattern for the all-true command |
| startIdx | input | 64 | Start index for the bound test |
| endIdx | input | 64 | End bound for the bound test |
| govPred | input | VL_BITS/8 | Governing predicate for flag evaluation |
| done | output | 1 | Pulses the cycle after a strobe |
| predOut | output | VL_BITS/8 | Registered result predicate, one bit per byte |
| flagsOut | output | 4 | Registered {N, Z, C, V} |
| countOut | output | clog2(VL_BITS/8)+1 | Registered element count |

## Verification
The predicate and its flags are updated in the same edge, and so the element-count command and a predicate-building command can meet in back-to-back cycles. The bench issues a bound test followed at once by an element count, with no gap between the two strobes. It then checks that the predicate and flags from the first command survive the second, that the count reflects the second command's element size, and that `done` stays high for both cycles and drops after them. Flag correctness is judged by sweeping start and end around zero and near the overflow points for every element size, with several governing patterns including an empty one.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [1:0] {
    CMD_WHILE_S = 2'd0,
    CMD_WHILE_U = 2'd1,
    CMD_ALLTRUE = 2'd2,
    CMD_COUNT   = 2'd3
  } lpgCmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPred;
    logic loadCount;
    logic selWhile;
    logic signedCmp;
  } lpgStrobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
  import lpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  lpgCmd_e    cmd,
  output lpgStrobe_t strb,
  output logic       done
);

  always_comb begin
    strb.loadPred  = cmdValid && (cmd != CMD_COUNT);
    strb.loadCount = cmdValid && (cmd == CMD_COUNT);
    strb.selWhile  = (cmd == CMD_WHILE_S) || (cmd == CMD_WHILE_U);
    strb.signedCmp = (cmd == CMD_WHILE_S);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= cmdValid;
  end

  // R10: completion pulse follows every strobe and nothing else
  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> done);
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !done);

endmodule

// File: rtl/lpg_datapath.sv
module lpg_datapath
  import lpg_pkg::*;
#(
  parameter int VL_BITS = 256
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  lpgStrobe_t                           strb,
  input  logic [63:0]                          startIdx,
  input  logic [63:0]                          endIdx,
  input  logic [1:0]                           elemSize,
  input  logic [2:0]                           pattern,
  input  logic [VL_BITS/8-1:0]                 govPred,
  output logic [VL_BITS/8-1:0]                 predOut,
  output logic [3:0]                           flagsOut,
  output logic [$clog2(VL_BITS/8):0]           countOut
);

  localparam int PB = VL_BITS / 8;
  localparam int CW = $clog2(PB) + 1;

  logic [CW-1:0] laneCount;
  logic [CW-1:0] pow2Count;
  logic [CW-1:0] fixedCount;
  logic [CW-1:0] patCount;
  logic [PB-1:0] ltVec;
  logic [PB-1:0] lowMask;
  logic [PB-1:0] newPred;
  logic          nFlag, zFlag, cFlag, seenActive;

  assign laneCount = CW'(PB >> elemSize);

  // Per-lane bound comparison on 66-bit extended operands (no wraparound)
  for (genvar k = 0; k < PB; k++) begin : g_lane
    logic [65:0] sumW;
    logic [65:0] endW;
    assign sumW = (strb.signedCmp ? {{2{startIdx[63]}}, startIdx}
                                  : {2'b00, startIdx}) + 66'(k);
    assign endW = strb.signedCmp ? {{2{endIdx[63]}}, endIdx} : {2'b00, endIdx};
    assign ltVec[k] = strb.signedCmp ? ($signed(sumW) < $signed(endW))
                                     : (sumW < endW);
  end

  // Lane count for the all-true patterns
  always_comb begin
    pow2Count = '0;
    for (int p = 0; p < CW; p++) begin
      if ((CW'(1) << p) <= laneCount) pow2Count = CW'(1) << p;
    end
    fixedCount = CW'(1) << pattern[1:0];
    case (pattern)
      3'd0:    patCount = laneCount;
      3'd1:    patCount = laneCount - (laneCount % CW'(3));
      3'd2:    patCount = laneCount & ~CW'(3);
      3'd3:    patCount = pow2Count;
      default: patCount = (fixedCount <= laneCount) ? fixedCount : '0;
    endcase
  end

  // Byte-granular result: only the lowest byte of each element may be set
  always_comb begin
    for (int b = 0; b < PB; b++) begin
      int e;
      logic on;
      e = b >> elemSize;
      lowMask[b] = ((b & ((1 << elemSize) - 1)) == 0);
      on = strb.selWhile ? ltVec[e] : (CW'(e) < patCount);
      newPred[b] = lowMask[b] && on;
    end
  end

  // Flags against the governing predicate
  always_comb begin
    seenActive = 1'b0;
    nFlag = 1'b0;
    zFlag = 1'b1;
    cFlag = 1'b1;
    for (int b = 0; b < PB; b++) begin
      if (lowMask[b] && govPred[b]) begin
        if (!seenActive) nFlag = newPred[b];
        seenActive = 1'b1;
        if (newPred[b]) zFlag = 1'b0;
        cFlag = !newPred[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predOut  <= '0;
      flagsOut <= '0;
      countOut <= '0;
    end else begin
      if (strb.loadPred) begin
        predOut  <= newPred;
        flagsOut <= {nFlag, zFlag, cFlag, 1'b0};
      end
      if (strb.loadCount) countOut <= laneCount;
    end
  end

  // R9: overflow flag never set
  a_r9_v_clear: assert property (@(posedge clk) disable iff (!rstN)
    !flagsOut[FLAG_V]);
  // R7: an all-false result must report no true active element
  a_r7_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPred |=> ((predOut != '0) || flagsOut[FLAG_Z]));
  // R6 / R8: with no true active element, first is false and last is not true
  a_r8_z_consistent: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPred |=> (!flagsOut[FLAG_Z] || (flagsOut[FLAG_C] && !flagsOut[FLAG_N])));
  // R1: start at or past the bound gives an empty predicate
  a_r1_empty_when_done: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPred && strb.selWhile && strb.signedCmp &&
     ($signed(startIdx) >= $signed(endIdx))) |=> (predOut == '0));
  // R5 / R10: predicate holds when no predicate command is sampled
  a_r10_pred_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPred |=> $stable(predOut));

endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
  import lpg_pkg::*;
#(
  parameter int VL_BITS = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmd,
  input  logic [1:0]                  elemSize,
  input  logic [2:0]                  pattern,
  input  logic [63:0]                 startIdx,
  input  logic [63:0]                 endIdx,
  input  logic [VL_BITS/8-1:0]        govPred,
  output logic                        done,
  output logic [VL_BITS/8-1:0]        predOut,
  output logic [3:0]                  flagsOut,
  output logic [$clog2(VL_BITS/8):0]  countOut
);

  lpgStrobe_t strb;

  lpg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmd      (lpgCmd_e'(cmd)),
    .strb     (strb),
    .done     (done)
  );

  lpg_datapath #(.VL_BITS(VL_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startIdx (startIdx),
    .endIdx   (endIdx),
    .elemSize (elemSize),
    .pattern  (pattern),
    .govPred  (govPred),
    .predOut  (predOut),
    .flagsOut (flagsOut),
    .countOut (countOut)
  );

endmodule

// File: tb/loop_pred_gen_tb.sv
module loop_pred_gen_tb;

  localparam int VL = 256;
  localparam int PB = VL / 8;
  localparam int CW = $clog2(PB) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmd = '0;
  logic [1:0]    elemSize = '0;
  logic [2:0]    pattern = '0;
  logic [63:0]   startIdx = '0;
  logic [63:0]   endIdx = '0;
  logic [PB-1:0] govPred = '1;
  logic          done;
  logic [PB-1:0] predOut;
  logic [3:0]    flagsOut;
  logic [CW-1:0] countOut;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  loop_pred_gen #(.VL_BITS(VL)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd),
    .elemSize(elemSize), .pattern(pattern), .startIdx(startIdx),
    .endIdx(endIdx), .govPred(govPred), .done(done), .predOut(predOut),
    .flagsOut(flagsOut), .countOut(countOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result predicate, computed from the requirement text
  function automatic logic [PB-1:0] expPred(input int kind, input logic [63:0] s,
      input logic [63:0] e, input int esz, input int pat);
    logic [PB-1:0] r;
    int lanes, step, cnt;
    logic signed [67:0] ss, es;
    logic [67:0] us, ue;
    bit on;
    r = '0;
    lanes = PB >> esz;
    step = 1 << esz;
    case (pat)
      0: cnt = lanes;
      1: cnt = (lanes / 3) * 3;
      2: cnt = (lanes / 4) * 4;
      3: begin cnt = 1; while (cnt * 2 <= lanes) cnt = cnt * 2; end
      default: begin cnt = 1 << (pat - 4); if (cnt > lanes) cnt = 0; end
    endcase
    for (int k = 0; k < lanes; k++) begin
      ss = $signed({{4{s[63]}}, s}) + 68'(k);
      es = $signed({{4{e[63]}}, e});
      us = {4'b0, s} + 68'(k);
      ue = {4'b0, e};
      if (kind == 0)      on = (ss < es);
      else if (kind == 1) on = (us < ue);
      else                on = (k < cnt);
      r[k * step] = on;
    end
    return r;
  endfunction

  function automatic logic [3:0] expFlags(input logic [PB-1:0] p,
      input logic [PB-1:0] g, input int esz);
    int lanes, step;
    bit seen, n, z, c;
    lanes = PB >> esz;
    step = 1 << esz;
    seen = 0; n = 0; z = 1; c = 1;
    for (int k = 0; k < lanes; k++) begin
      if (g[k * step]) begin
        if (!seen) n = p[k * step];
        seen = 1;
        if (p[k * step]) z = 0;
        c = !p[k * step];
      end
    end
    return {n, z, c, 1'b0};
  endfunction

  task automatic issue(input logic [1:0] c, input int esz, input int pat,
                       input logic [63:0] s, input logic [63:0] e,
                       input logic [PB-1:0] g);
    @(negedge clk);
    cmd = c; elemSize = 2'(esz); pattern = 3'(pat);
    startIdx = s; endIdx = e; govPred = g; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic runPred(input int kind, input int esz, input int pat,
                         input logic [63:0] s, input logic [63:0] e,
                         input logic [PB-1:0] g, input string tag);
    logic [PB-1:0] ep;
    logic [3:0] ef;
    ep = expPred(kind, s, e, esz, pat);
    ef = expFlags(ep, g, esz);
    issue(2'(kind), esz, pat, s, e, g);
    chk(predOut == ep, {tag, " R3 predicate"}, 64'(predOut), 64'(ep));
    chk(flagsOut == ef, {tag, " R6 R7 R8 R9 flags"}, 64'(flagsOut), 64'(ef));
    chk(done == 1'b1, {tag, " R10 done"}, 64'(done), 64'd1);
  endtask

  logic [PB-1:0] govSet [4];

  initial begin
    govSet[0] = '1;
    govSet[1] = '0;
    govSet[2] = PB'(32'hF0F0_F0F0);
    govSet[3] = PB'(32'h0F0F_0101);

    repeat (3) @(negedge clk);
    // R11: reset state
    chk(predOut == '0, "R11 pred reset", 64'(predOut), 64'd0);
    chk(flagsOut == '0, "R11 flags reset", 64'(flagsOut), 64'd0);
    chk(countOut == '0, "R11 count reset", 64'(countOut), 64'd0);
    chk(done == 1'b0, "R11 done reset", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: all-true patterns, every size
    for (int esz = 0; esz < 4; esz++)
      for (int pat = 0; pat < 8; pat++)
        runPred(2, esz, pat, 64'd0, 64'd0, '1, "R4 alltrue");

    // R4: 32-bit lanes, multiple of three -> 6 of 8 lanes
    issue(2'd2, 2, 1, 64'd0, 64'd0, '1);
    chk(predOut == PB'(32'h0011_1111), "R4 mul3 eight lanes", 64'(predOut),
        64'h0011_1111);

    // R1 / R2: bound test sweep around zero, several governing patterns
    for (int kind = 0; kind < 2; kind++)
      for (int esz = 0; esz < 4; esz++)
        for (int s = -4; s <= 4; s++)
          for (int e = -4; e <= 4; e++) begin
            longint sl, el;
            sl = longint'(s);
            el = longint'(e);
            runPred(kind, esz, 0, 64'(sl), 64'(el), govSet[(s + e + 8) % 4],
                    kind == 0 ? "R1 signed sweep" : "R2 unsigned sweep");
          end

    // R1: signed overflow point, lanes past max positive are false
    runPred(0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, '1,
            "R1 signed no wrap");
    chk(predOut == PB'(1), "R1 only lane zero", 64'(predOut), 64'd1);
    // R2: unsigned overflow point
    runPred(1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, '1,
            "R2 unsigned no wrap");
    chk(predOut == PB'(1), "R2 only lane zero", 64'(predOut), 64'd1);
    // R2: large bound, partial vector
    runPred(1, 1, 0, 64'd10, 64'd20, '1, "R2 partial");

    // R8: empty governing predicate -> N0 Z1 C1
    issue(2'd2, 0, 0, 64'd0, 64'd0, '0);
    chk(flagsOut == 4'b0110, "R8 empty governing", 64'(flagsOut), 64'b0110);

    // R5: element count leaves predicate and flags alone
    runPred(1, 2, 0, 64'd0, 64'd3, '1, "R5 setup");
    for (int esz = 0; esz < 4; esz++) begin
      logic [PB-1:0] keepP;
      logic [3:0] keepF;
      keepP = predOut;
      keepF = flagsOut;
      issue(2'd3, esz, 0, 64'd100, 64'd0, '0);
      chk(countOut == CW'(PB >> esz), "R5 count", 64'(countOut), 64'(PB >> esz));
      chk(predOut == keepP, "R5 pred kept", 64'(predOut), 64'(keepP));
      chk(flagsOut == keepF, "R5 flags kept", 64'(flagsOut), 64'(keepF));
    end

    // R10: back-to-back bound test then element count
    begin
      logic [PB-1:0] ep;
      logic [3:0] ef;
      ep = expPred(0, 64'd1, 64'd4, 1, 0);
      ef = expFlags(ep, '1, 1);
      @(negedge clk);
      cmd = 2'd0; elemSize = 2'd1; startIdx = 64'd1; endIdx = 64'd4;
      govPred = '1; cmdValid = 1'b1;
      @(negedge clk);
      chk(predOut == ep, "R10 first of pair pred", 64'(predOut), 64'(ep));
      chk(done == 1'b1, "R10 first done", 64'(done), 64'd1);
      cmd = 2'd3; elemSize = 2'd3;
      @(negedge clk);
      cmdValid = 1'b0;
      chk(countOut == CW'(PB >> 3), "R10 second count", 64'(countOut), 64'(PB >> 3));
      chk(predOut == ep, "R10 pred survives", 64'(predOut), 64'(ep));
      chk(flagsOut == ef, "R10 flags survive", 64'(flagsOut), 64'(ef));
      chk(done == 1'b1, "R10 second done", 64'(done), 64'd1);
      cmd = 2'd2; elemSize = 2'd0;
      @(negedge clk);
      chk(done == 1'b0, "R10 done drops", 64'(done), 64'd0);
      chk(predOut == ep, "R10 no strobe hold", 64'(predOut), 64'(ep));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule